// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block takes a three-wire serial audio stream and turns it into parallel words. The three wires are a bit clock, a square-wave word-select line at the sample rate, and a data line. The block runs directly on the bit clock and has a synchronous reset. It finds the stereo frame boundary only at a genuine low-to-high transition of the word-select line. A high level alone never starts capture, because arriving in the middle of the left channel would misalign the frame.

Once locked, a free-running bit counter tracks every word, channel and frame boundary, and the block needs no further sync marks. Each 64-bit frame is delivered as four 16-bit words, each with a one-cycle strobe, a slot index and a left/right flag.

The word-select level is compared with the counter on every bit. If the two disagree, lock is dropped and the search for a rising edge starts again.

Top module: `serial_frame_rx`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `bit_clk` edge) leaves `locked` = 0, `word_valid` = 0 and `word_data` = 0 from the next cycle on.
- R2: After reset the receiver stays unlocked, captures nothing and raises no strobe until two consecutive post-reset samples of `ws_in` read 0 then 1. A `ws_in` that is already high on the first sample after reset does not count as an edge.
- R3: Data is sampled on the rising `bit_clk` edge, MSB first. The bit sampled together with the detected rising edge is bit 0 of the frame (the MSB of slot 0). A word holds 16 bits.
- R4: A frame is 64 bits, delivered as slot 0 (left, upper half), slot 1 (left, lower), slot 2 (right, upper) and slot 3 (right, lower). `word_left` is the `ws_in` level sampled at the first bit of the word, so it reads 1 for slots 0 and 1 and 0 for slots 2 and 3.
- R5: `word_valid` is high for exactly one cycle, in the cycle after the edge that samples the 16th bit of a word. `word_data`, `word_slot` and `word_left` hold their values between strobes.
- R6: While locked, consecutive frames are deserialized back to back by counting alone, with no further sync needed.
- R7: While locked, `ws_in` must read 1 at bit positions 0 to 31 and 0 at positions 32 to 63. A sample that breaks this clears `locked` and is discarded, and the unfinished word produces no strobe.
- R8: After lock is lost, the search starts again from the next sample. The next 0-to-1 transition of `ws_in` relocks and starts a new frame at bit 0.
- R9: `locked` goes high in the cycle after the edge that detects the rising transition, and it stays high while the word-select pattern matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ws_in | input | 1 | Word-select line: high for the left channel, low for the right |
| sd_in | input | 1 | Serial data, MSB first |
| locked | output | 1 | Frame alignment established |
| word_valid | output | 1 | One-cycle strobe: a new word is on `word_data` |
| word_data | output | WORD_W (16) | Deserialized word |
| word_slot | output | 2 | Slot index of the word within the frame, 0 to 3 |
| word_left | output | 1 | Channel flag of the word: 1 for left, 0 for right |

## Verification
The following properties are checked on every cycle:
- the strobe lasts a single cycle and is only ever seen while locked;
- the output word is stable between strobes;
- the channel flag agrees with the slot half;
- every lock is preceded by a low sample followed by a high one;
- reset clears the outputs.

Some behaviour can only be shown by the bench's scenarios:
- the exact bit ordering and MSB alignment of the data against a known frame;
- rejection of a high level seen right after reset;
- loss of lock at an early transition and at a missing transition;
- relocking on the next genuine rising edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [0:0] {
      TRK_SEARCH = 1'b0,
      TRK_ALIGNED = 1'b1
   } trk_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sfr_ws_sampler.sv
module sfr_ws_sampler (
   input  logic clk,
   input  logic rst,
   input  logic ws,
   output logic ws_prev,
   output logic prev_ok
);
   // prev_ok marks that ws_prev holds a post-reset sample
   always_ff @(posedge clk) begin
      ws_prev <= ws;
      if (rst) prev_ok <= 1'b0;
      else     prev_ok <= 1'b1;
   end
endmodule

// File: rtl/sfr_tracker.sv
module sfr_tracker
   import sfr_pkg::*;
#(
   parameter int unsigned FRAME_W = 64,
   localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ws,
   input  logic             ws_prev,
   input  logic             prev_ok,
   output logic             aligned,
   output logic             cap,
   output logic [CNT_W-1:0] idx
);
   trk_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             rise;
   logic             want_lvl;
   logic             clash;

   always_comb begin
      rise     = prev_ok & ~ws_prev & ws;
      // first half of the frame is left (high), second half right (low)
      want_lvl = ~cnt[CNT_W-1];
      clash    = (st == TRK_ALIGNED) && (ws != want_lvl);
      cap      = (st == TRK_SEARCH) ? rise : ~clash;
      idx      = (st == TRK_SEARCH) ? '0 : cnt;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= TRK_SEARCH;
         cnt <= '0;
      end else if (st == TRK_SEARCH) begin
         if (rise) begin
            st  <= TRK_ALIGNED;
            cnt <= CNT_W'(1);
         end
      end else if (clash) begin
         st  <= TRK_SEARCH;
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);   // wraps at FRAME_W (power of two)
      end
   end

   assign aligned = (st == TRK_ALIGNED);
endmodule

// File: rtl/sfr_assembler.sv
module sfr_assembler #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned FRAME_W = 64,
   localparam int unsigned CNT_W  = $clog2(FRAME_W),
   localparam int unsigned POS_W  = $clog2(WORD_W),
   localparam int unsigned SLOT_W = CNT_W - POS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic [CNT_W-1:0]  idx,
   input  logic              sd,
   input  logic              ws,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic [SLOT_W-1:0] word_slot,
   output logic              word_left
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] shnext;
   logic [POS_W-1:0]  pos;
   logic              chan_q;

   assign pos    = idx[POS_W-1:0];
   assign shnext = {shreg[WORD_W-2:0], sd};

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg      <= '0;
         chan_q     <= 1'b0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_slot  <= '0;
         word_left  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (cap) begin
            shreg <= shnext;
            if (pos == '0) chan_q <= ws;
            if (pos == LAST_POS) begin
               word_valid <= 1'b1;
               word_data  <= shnext;
               word_slot  <= idx[CNT_W-1:POS_W];
               word_left  <= chan_q;
            end
         end
      end
   end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
   import sfr_pkg::*;
#(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned FRAME_W = 64,
   localparam int unsigned CNT_W  = $clog2(FRAME_W),
   localparam int unsigned SLOT_W = CNT_W - $clog2(WORD_W)
) (
   input  logic              bit_clk,
   input  logic              rst,
   input  logic              ws_in,
   input  logic              sd_in,
   output logic              locked,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic [SLOT_W-1:0] word_slot,
   output logic              word_left
);
   generate
      if (!is_pow2(WORD_W) || WORD_W < 2) begin : g_bad_word
         $error("serial_frame_rx: WORD_W must be a power of two, at least 2");
      end
      if (!is_pow2(FRAME_W) || FRAME_W < 2 * WORD_W) begin : g_bad_frame
         $error("serial_frame_rx: FRAME_W must be a power of two holding two words or more");
      end
   endgenerate

   logic             ws_prev;
   logic             prev_ok;
   logic             cap;
   logic [CNT_W-1:0] idx;

   sfr_ws_sampler u_smp (
      .clk     (bit_clk),
      .rst     (rst),
      .ws      (ws_in),
      .ws_prev (ws_prev),
      .prev_ok (prev_ok)
   );

   sfr_tracker #(.FRAME_W(FRAME_W)) u_trk (
      .clk     (bit_clk),
      .rst     (rst),
      .ws      (ws_in),
      .ws_prev (ws_prev),
      .prev_ok (prev_ok),
      .aligned (locked),
      .cap     (cap),
      .idx     (idx)
   );

   sfr_assembler #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_asm (
      .clk        (bit_clk),
      .rst        (rst),
      .cap        (cap),
      .idx        (idx),
      .sd         (sd_in),
      .ws         (ws_in),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_slot  (word_slot),
      .word_left  (word_left)
   );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned FRAME_W = 64,
   localparam int unsigned SLOT_W = $clog2(FRAME_W) - $clog2(WORD_W),
   localparam int unsigned HALF_SLOTS = (FRAME_W / WORD_W) / 2
) (
   input logic              bit_clk,
   input logic              rst,
   input logic              ws_in,
   input logic              locked,
   input logic              word_valid,
   input logic [WORD_W-1:0] word_data,
   input logic [SLOT_W-1:0] word_slot,
   input logic              word_left
);
   a_r1_reset_clears: assert property (@(posedge bit_clk)
      rst |=> (!locked && !word_valid && word_data == '0));

   a_r3_strobe_only_locked: assert property (@(posedge bit_clk) disable iff (rst)
      word_valid |-> locked);

   a_r4_flag_matches_slot: assert property (@(posedge bit_clk) disable iff (rst)
      word_valid |-> (word_left == (int'(word_slot) < HALF_SLOTS)));

   a_r5_single_cycle: assert property (@(posedge bit_clk) disable iff (rst)
      word_valid |=> !word_valid);

   a_r5_hold_between: assert property (@(posedge bit_clk) disable iff (rst)
      (!word_valid && $past(!rst)) |-> $stable(word_data));

   a_r9_lock_after_rise: assert property (@(posedge bit_clk) disable iff (rst)
      $rose(locked) |-> ($past(ws_in) && !$past(ws_in, 2)));
endmodule

bind serial_frame_rx sfr_checker #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_chk (
   .bit_clk    (bit_clk),
   .rst        (rst),
   .ws_in      (ws_in),
   .locked     (locked),
   .word_valid (word_valid),
   .word_data  (word_data),
   .word_slot  (word_slot),
   .word_left  (word_left)
);

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb;
   logic        bit_clk = 1'b0;
   logic        rst = 1'b1;
   logic        ws_in = 1'b0;
   logic        sd_in = 1'b0;
   logic        locked;
   logic        word_valid;
   logic [15:0] word_data;
   logic [1:0]  word_slot;
   logic        word_left;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 bit_clk = ~bit_clk;

   serial_frame_rx u_dut (
      .bit_clk(bit_clk), .rst(rst), .ws_in(ws_in), .sd_in(sd_in),
      .locked(locked), .word_valid(word_valid), .word_data(word_data),
      .word_slot(word_slot), .word_left(word_left)
   );

   localparam logic [63:0] FRAMES [4] = '{
      64'h8001_7FFE_C3A5_5A3C,
      64'hFFFF_0000_0000_FFFF,
      64'h1234_5678_9ABC_DEF0,
      64'hA5A5_5A5A_0F0F_F0F0
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive one bit at a falling edge; return after the next falling edge,
   // when the outputs reflect the rising edge that sampled this bit
   task automatic tick(input logic ws, input logic d);
      ws_in = ws;
      sd_in = d;
      @(negedge bit_clk);
   endtask

   task automatic quiet(input string req);
      chk(locked == 1'b0, req, "locked while searching", 32'(locked), 0);
      chk(word_valid == 1'b0, req, "strobe while searching", 32'(word_valid), 0);
   endtask

   // one locked frame: bit i of the frame is f[63-i]
   task automatic good_bit(input logic [63:0] f, input int i, input string req);
      tick(i < 32, f[63-i]);
      chk(locked == 1'b1, req, "lock held", 32'(locked), 1);
      if (i % 16 == 15) begin
         chk(word_valid == 1'b1, req, "strobe at word end", 32'(word_valid), 1);
         chk(word_data == f[63-16*(i/16) -: 16], req, "word data",
             32'(word_data), 32'(f[63-16*(i/16) -: 16]));
         chk(word_slot == 2'(i/16), req, "slot index", 32'(word_slot), 32'(i/16));
         chk(word_left == (i < 32), req, "channel flag", 32'(word_left), 32'(i < 32));
      end else begin
         chk(word_valid == 1'b0, req, "strobe mid word", 32'(word_valid), 0);
      end
   endtask

   task automatic good_frame(input logic [63:0] f, input string req);
      for (int i = 0; i < 64; i++) good_bit(f, i, req);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
      chk(locked == 1'b0, "R1", "locked after reset", 32'(locked), 0);
      chk(word_valid == 1'b0, "R1", "strobe after reset", 32'(word_valid), 0);
      chk(word_data == 16'h0, "R1", "data after reset", 32'(word_data), 0);
      rst = 1'b0;
   endtask

   initial begin
      @(negedge bit_clk);
      do_reset();

      // R2: high on first post-reset sample (low during reset) is no edge
      for (int i = 0; i < 32; i++) begin tick(1'b1, i[0] ^ i[2]); quiet("R2"); end
      for (int i = 0; i < 32; i++) begin tick(1'b0, i[1]); quiet("R2"); end

      // table walk: lock on the rising edge and run back-to-back frames
      // R3 R4 R5 R6 R9
      foreach (FRAMES[k]) good_frame(FRAMES[k], (k == 0) ? "R9" : "R6");

      // R7: missing falling edge at bit 32
      for (int i = 0; i < 32; i++) good_bit(64'hBEEF_CAFE_1357_2468, i, "R4");
      tick(1'b1, 1'b1);
      quiet("R7");
      for (int i = 33; i < 64; i++) begin tick(1'b0, 1'b1); quiet("R7"); end
      good_frame(64'h0F1E_2D3C_4B5A_6978, "R8");

      // R7: early transition at bit 10 discards the partial word
      for (int i = 0; i < 10; i++) good_bit(64'hFFFF_FFFF_0000_0000, i, "R7");
      tick(1'b0, 1'b1);
      quiet("R7");
      for (int i = 11; i < 64; i++) begin tick(1'b0, 1'b1); quiet("R7"); end
      chk(word_data == 16'h4B5A || word_data == 16'h6978, "R5", "data held after loss",
          32'(word_data), 32'h6978);
      good_frame(64'h7654_3210_FEDC_BA98, "R8");

      // reset in the middle of a locked frame
      for (int i = 0; i < 20; i++) good_bit(64'h1111_2222_3333_4444, i, "R6");
      do_reset();
      for (int i = 0; i < 8; i++) begin tick(1'b0, 1'b0); quiet("R2"); end
      good_frame(64'h0001_8000_FFFE_7FFF, "R3");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule